// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block keeps wall-clock time as a 32-bit count of whole seconds. It advances by one on each one-cycle seconds tick while its run bit is set, and it wraps from all ones back to zero. A 32-bit alarm value is compared against the count. When the two match while the alarm is enabled, a pending flag is set and drives the interrupt line high. The line stays high until software clears it by writing one to a separate clear bit.

Software reaches the block through a byte-wide register file. Three registers are used for setting the time.

- **Run register.** It holds the run bit.
- **Staging bytes.** Bytes 1 to 3 of the new time are written here first, which has no effect on the count.
- **Byte 0.** Writing byte 0 commits the full value to the counter in a single cycle.

The count is read as four live bytes, with no snapshot taken. A carry can therefore land between two byte reads. Software detects this by re-reading byte 0 and checking whether it went down.

The expected way to set the time is as follows:

1. Disable the alarm.
2. Stop the counter.
3. Write byte 0 as zero.
4. Write bytes 1 to 3.
5. Write byte 0.
6. Restart the counter and re-enable the alarm.

Top module: `sec_rtc`

## Requirements
- R1: After synchronous active-high reset, the count, every control byte, the staging bytes and the alarm value are zero, the interrupt is low, and every address reads 0x00.
- R2: Read data appears on rdata the cycle after rd_en and holds until the next read. The register map is as follows:
  - 0x0 is the run control byte, read/write.
  - 0x1 is the alarm control byte, all 8 bits read/write.
  - 0x6 to 0x9 hold count bytes 0 to 3, least significant byte first.
  - 0xA to 0xD hold alarm value bytes 0 to 3, read/write.
  - 0x2 to 0x5, 0xE and 0xF read as 0x00.
- R3: The count increases by exactly one on a tick_en pulse when bit 7 of the run control byte is 1. While that bit is 0, ticks leave the count unchanged.
- R4: A tick at count 0xFFFFFFFF yields 0x00000000.
- R5: Writes to 0x3, 0x4 and 0x5 stage count bytes 1, 2 and 3 and leave the count unchanged. A write to 0x2 loads {staged byte 3, 2, 1, written byte} into the count in one cycle. That load takes precedence over a tick in the same cycle.
- R6: The time-setting order given above ends with exactly the written value in the count. Ticks that arrive while the counter is stopped are lost.
- R7: Count bytes are read live, so a tick between byte reads is visible: byte 0 read again after a carry is smaller than before.
- R8: The pending flag, and with it alarm_irq, rises the cycle after the condition (count equals alarm value and alarm control bit 7 is 1) becomes true. It stays high until cleared.
- R9: With alarm control bit 7 at 0, a count equal to the alarm value never raises alarm_irq.
- R10: Writing 0x0E with bit 0 set drops alarm_irq on the next cycle, and 0x0E reads back 0x00. A write with bit 0 clear has no effect. The interrupt does not return while the match merely persists.
- R11: If a clear write lands in the same cycle in which a new match event sets the flag, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle seconds tick |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| alarm_irq | output | 1 | Alarm interrupt, high while an alarm is pending |

## Verification
The bound checker watches the count on every cycle for the following properties:
- it holds while stopped;
- it takes exactly one step per enabled tick;
- it commits the staged value on a byte 0 write.

It also checks the interrupt on every cycle:
- it rises only after a match event;
- it stays set until cleared;
- it drops on a clear, except when a new event arrives in the same cycle.

Only the directed scenarios can show the following:
- the register map and readback;
- that the full time-setting order gives the right end value;
- torn live reads across a carry;
- the wrap at all ones;
- that a persisting match does not re-raise the interrupt once it has been cleared.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned RUN_BIT      = 7;
  localparam int unsigned ALARM_EN_BIT = 7;
  localparam int unsigned CLEAR_BIT    = 0;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_CTRL,
    RK_ACTL,
    RK_TSET,
    RK_TLIVE,
    RK_AVAL,
    RK_ACLR
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [2:0] idx;
  } reg_sel_t;

  // Map an address onto a register kind and a byte index, for nb count bytes.
  function automatic reg_sel_t decode_addr(input int unsigned a, input int unsigned nb);
    reg_sel_t    s;
    int unsigned tset_base;
    int unsigned tlive_base;
    int unsigned aval_base;
    int unsigned aclr_addr;
    tset_base  = 2;
    tlive_base = tset_base + nb;
    aval_base  = tlive_base + nb;
    aclr_addr  = aval_base + nb;
    s.kind = RK_NONE;
    s.idx  = '0;
    if (a == 0) begin
      s.kind = RK_CTRL;
    end else if (a == 1) begin
      s.kind = RK_ACTL;
    end else if (a < tlive_base) begin
      s.kind = RK_TSET;
      s.idx  = 3'(a - tset_base);
    end else if (a < aval_base) begin
      s.kind = RK_TLIVE;
      s.idx  = 3'(a - tlive_base);
    end else if (a < aclr_addr) begin
      s.kind = RK_AVAL;
      s.idx  = 3'(a - aval_base);
    end else if (a == aclr_addr) begin
      s.kind = RK_ACLR;
    end
    return s;
  endfunction

  // Select byte i of a value, least significant byte first.
  function automatic logic [BYTE_W-1:0] byte_of(input logic [63:0] v, input int unsigned i);
    return v[i*BYTE_W +: BYTE_W];
  endfunction

endpackage

// File: rtl/sec_rtc_counter.sv
module sec_rtc_counter #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] count
);

  logic step;
  assign step = run && tick && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (step) begin
      count <= count + CW'(1);
    end
  end

endmodule

// File: rtl/sec_rtc_regfile.sv
module sec_rtc_regfile
  import sec_rtc_pkg::*;
#(
  parameter int unsigned NB = 4,
  parameter int unsigned AW = 4,
  localparam int unsigned CW = NB * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [BYTE_W-1:0] actl_q,
  output logic [CW-1:0]     alarm_val,
  output logic [CW-1:0]     load_val,
  output logic              load_ev,
  output logic              clr_ev
);

  reg_sel_t          wsel;
  logic [BYTE_W-1:0] stage_b [1:NB-1];
  logic [BYTE_W-1:0] alarm_b [NB];

  assign wsel = decode_addr(32'(addr), NB);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      actl_q <= '0;
      for (int i = 1; i < NB; i++) stage_b[i] <= '0;
      for (int i = 0; i < NB; i++) alarm_b[i] <= '0;
    end else if (wr_en) begin
      case (wsel.kind)
        RK_CTRL: ctrl_q <= wdata;
        RK_ACTL: actl_q <= wdata;
        RK_TSET: begin
          for (int i = 1; i < NB; i++)
            if (wsel.idx == 3'(i)) stage_b[i] <= wdata;
        end
        RK_AVAL: begin
          for (int i = 0; i < NB; i++)
            if (wsel.idx == 3'(i)) alarm_b[i] <= wdata;
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_alarm_pack
    assign alarm_val[g*BYTE_W +: BYTE_W] = alarm_b[g];
  end

  for (genvar g = 1; g < NB; g++) begin : g_stage_pack
    assign load_val[g*BYTE_W +: BYTE_W] = stage_b[g];
  end
  assign load_val[BYTE_W-1:0] = wdata;

  assign load_ev = wr_en && (wsel.kind == RK_TSET) && (wsel.idx == 3'd0);
  assign clr_ev  = wr_en && (wsel.kind == RK_ACLR) && wdata[CLEAR_BIT];

endmodule

// File: rtl/sec_rtc_alarm.sv
module sec_rtc_alarm #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] alarm_val,
  input  logic          alarm_en,
  input  logic          clr,
  output logic          hit,
  output logic          hit_rise,
  output logic          pending
);

  logic hit_q;

  assign hit      = alarm_en && (count == alarm_val);
  assign hit_rise = hit && !hit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q   <= 1'b0;
      pending <= 1'b0;
    end else begin
      hit_q <= hit;
      if (hit_rise)  pending <= 1'b1;
      else if (clr)  pending <= 1'b0;
    end
  end

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import sec_rtc_pkg::*;
#(
  parameter int unsigned NB = 4,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [7:0]    wdata,
  input  logic          rd_en,
  output logic [7:0]    rdata,
  output logic          alarm_irq
);

  localparam int unsigned CW = NB * BYTE_W;

  logic [BYTE_W-1:0] ctrl_q;
  logic [BYTE_W-1:0] actl_q;
  logic [CW-1:0]     alarm_val;
  logic [CW-1:0]     load_val;
  logic              load_ev;
  logic              clr_ev;
  logic [CW-1:0]     count_q;
  logic              run;
  logic              hit;
  logic              hit_rise;
  logic              alarm_pend;
  reg_sel_t          rsel;
  logic [BYTE_W-1:0] rd_byte;
  logic [BYTE_W-1:0] rdata_q;

  sec_rtc_regfile #(.NB(NB), .AW(AW)) regs_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .ctrl_q    (ctrl_q),
    .actl_q    (actl_q),
    .alarm_val (alarm_val),
    .load_val  (load_val),
    .load_ev   (load_ev),
    .clr_ev    (clr_ev)
  );

  assign run = ctrl_q[RUN_BIT];

  sec_rtc_counter #(.CW(CW)) cnt_i (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .tick     (tick_en),
    .load     (load_ev),
    .load_val (load_val),
    .count    (count_q)
  );

  sec_rtc_alarm #(.CW(CW)) alm_i (
    .clk       (clk),
    .rst       (rst),
    .count     (count_q),
    .alarm_val (alarm_val),
    .alarm_en  (actl_q[ALARM_EN_BIT]),
    .clr       (clr_ev),
    .hit       (hit),
    .hit_rise  (hit_rise),
    .pending   (alarm_pend)
  );

  assign rsel = decode_addr(32'(addr), NB);

  always_comb begin
    case (rsel.kind)
      RK_CTRL:  rd_byte = ctrl_q;
      RK_ACTL:  rd_byte = actl_q;
      RK_TLIVE: rd_byte = byte_of(64'(count_q), 32'(rsel.idx));
      RK_AVAL:  rd_byte = byte_of(64'(alarm_val), 32'(rsel.idx));
      default:  rd_byte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_byte;
  end

  assign rdata     = rdata_q;
  assign alarm_irq = alarm_pend;

endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk #(
  parameter int unsigned CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          tick_en,
  input logic          run,
  input logic          load_ev,
  input logic          clr_ev,
  input logic          hit_rise,
  input logic [CW-1:0] count_q,
  input logic [CW-1:0] load_val,
  input logic          alarm_irq,
  input logic          rd_en,
  input logic [3:0]    addr,
  input logic [7:0]    rdata
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (count_q == '0) && !alarm_irq && (rdata == 8'h00));

  // R3
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !load_ev) |=> $stable(count_q));

  // R3
  tick_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && tick_en && !load_ev) |=> (count_q == $past(count_q) + CW'(1)));

  // R5
  load_commit_chk: assert property (@(posedge clk) disable iff (rst)
    load_ev |=> (count_q == $past(load_val)));

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_irq) |-> $past(hit_rise));

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (alarm_irq && !clr_ev) |=> alarm_irq);

  // R10
  clear_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_ev && !hit_rise) |=> !alarm_irq);

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_ev && hit_rise) |=> alarm_irq);

  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 4'hF) |=> (rdata == 8'h00));

endmodule

bind sec_rtc sec_rtc_chk #(.CW(CW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .tick_en   (tick_en),
  .run       (run),
  .load_ev   (load_ev),
  .clr_ev    (clr_ev),
  .hit_rise  (hit_rise),
  .count_q   (count_q),
  .load_val  (load_val),
  .alarm_irq (alarm_irq),
  .rd_en     (rd_en),
  .addr      (4'(addr)),
  .rdata     (rdata)
);

// File: tb/sec_rtc_tb_top.sv
module sec_rtc_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;
  logic       alarm_irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sec_rtc dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .alarm_irq(alarm_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd_count(output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd(4'(6 + i), b);
      v[i*8 +: 8] = b;
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic load_time(input logic [31:0] v);
    wr(4'h3, v[15:8]); wr(4'h4, v[23:16]); wr(4'h5, v[31:24]); wr(4'h2, v[7:0]);
  endtask

  task automatic t_reset;
    logic [7:0] b;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), b);
      check("R1 reset read", 32'(b), 32'h0);
    end
    check("R1 reset irq", 32'(alarm_irq), 32'h0);
  endtask

  task automatic t_count_enable;
    logic [31:0] v; logic [7:0] b;
    tick(3); rd_count(v); check("R3 stopped ticks", v, 32'h0);
    wr(4'h0, 8'h80); rd(4'h0, b); check("R2 run byte readback", 32'(b), 32'h80);
    tick(5); rd_count(v); check("R3 running ticks", v, 32'h5);
    wr(4'h0, 8'h00); tick(4); rd_count(v); check("R3 stopped again", v, 32'h5);
  endtask

  task automatic t_staged_load;
    logic [31:0] v;
    wr(4'h3, 8'h56); wr(4'h4, 8'h34); wr(4'h5, 8'h12);
    rd_count(v); check("R5 staging leaves count", v, 32'h5);
    wr(4'h2, 8'h78); rd_count(v); check("R5 byte0 commit", v, 32'h12345678);
    wr(4'h0, 8'h80);
    @(negedge clk); tick_en = 1'b1; wr_en = 1'b1; addr = 4'h2; wdata = 8'h9A;
    @(negedge clk); tick_en = 1'b0; wr_en = 1'b0;
    rd_count(v); check("R5 load beats tick", v, 32'h1234569A);
    wr(4'h0, 8'h00);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    load_time(32'hFFFFFFFF); wr(4'h0, 8'h80);
    tick(1); rd_count(v); check("R4 wrap to zero", v, 32'h0);
    tick(1); rd_count(v); check("R4 after wrap", v, 32'h1);
  endtask

  task automatic t_set_time;
    logic [31:0] v; logic [7:0] b;
    wr(4'h1, 8'h80);
    wr(4'h1, 8'h00); wr(4'h0, 8'h00);
    wr(4'h2, 8'h00);
    rd_count(v); check("R6 byte0 zero commit", v, 32'hFFFFFF00); // staged bytes still FF from wrap test
    tick(2);
    wr(4'h3, 8'hC7); wr(4'h4, 8'hB6); wr(4'h5, 8'hA5);
    tick(1);
    rd_count(v); check("R6 count held while staging", v, 32'hFFFFFF00);
    wr(4'h2, 8'hD8);
    rd_count(v); check("R6 final value", v, 32'hA5B6C7D8);
    wr(4'h0, 8'h80); wr(4'h1, 8'h80);
    rd(4'h1, b); check("R2 alarm ctrl readback", 32'(b), 32'h80);
    tick(2); rd_count(v); check("R6 resumes", v, 32'hA5B6C7DA);
    check("R9 no irq after set time", 32'(alarm_irq), 32'h0);
    wr(4'h1, 8'h00);
  endtask

  task automatic t_live_read;
    logic [7:0] b0, b1, b0b;
    load_time(32'h000000FF);
    rd(4'h6, b0); check("R7 first byte0", 32'(b0), 32'hFF);
    tick(1);
    rd(4'h7, b1); check("R7 byte1 after carry", 32'(b1), 32'h01);
    rd(4'h6, b0b); check("R7 reread byte0", 32'(b0b), 32'h00);
    check("R7 carry visible", 32'(b0b < b0), 32'h1);
  endtask

  task automatic t_alarm_fire;
    logic [7:0] b;
    wr(4'h0, 8'h00);
    load_time(32'h0000000E);
    wr(4'hA, 8'h10); wr(4'hB, 8'h00); wr(4'hC, 8'h00); wr(4'hD, 8'h00);
    rd(4'hA, b); check("R2 alarm byte0 readback", 32'(b), 32'h10);
    rd(4'hD, b); check("R2 alarm byte3 readback", 32'(b), 32'h00);
    wr(4'h1, 8'h85); rd(4'h1, b); check("R2 alarm ctrl all bits", 32'(b), 32'h85);
    wr(4'h0, 8'h80);
    tick(1); idle(1); check("R8 no irq before match", 32'(alarm_irq), 32'h0);
    tick(1); idle(1); check("R8 irq on match", 32'(alarm_irq), 32'h1);
    tick(1); idle(1); check("R8 irq sticky", 32'(alarm_irq), 32'h1);
  endtask

  task automatic t_alarm_clear;
    logic [7:0] b;
    wr(4'hE, 8'h00); idle(1); check("R10 zero write no effect", 32'(alarm_irq), 32'h1);
    wr(4'hE, 8'h01); check("R10 clear drops irq", 32'(alarm_irq), 32'h0);
    rd(4'hE, b); check("R10 clear reads zero", 32'(b), 32'h00);
    wr(4'h0, 8'h00);
    wr(4'h2, 8'h10); idle(1); check("R8 load onto alarm", 32'(alarm_irq), 32'h1);
    wr(4'hE, 8'h01); idle(3); check("R10 no re-raise on held match", 32'(alarm_irq), 32'h0);
  endtask

  task automatic t_alarm_disabled;
    wr(4'h1, 8'h00);
    wr(4'h2, 8'h0F); wr(4'h0, 8'h80);
    tick(1); idle(2); check("R9 match with alarm off", 32'(alarm_irq), 32'h0);
    wr(4'h1, 8'h80); idle(1); check("R8 enable onto match", 32'(alarm_irq), 32'h1);
    wr(4'hE, 8'h01); check("R10 clear again", 32'(alarm_irq), 32'h0);
  endtask

  task automatic t_set_wins;
    wr(4'h2, 8'h0F);
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0; wr_en = 1'b1; addr = 4'hE; wdata = 8'h01;
    @(negedge clk); wr_en = 1'b0;
    check("R11 set beats clear", 32'(alarm_irq), 32'h1);
    wr(4'hE, 8'h01); check("R11 later clear works", 32'(alarm_irq), 32'h0);
  endtask

  task automatic t_unmapped;
    logic [7:0] b;
    wr(4'hF, 8'hAB);
    for (int a = 2; a < 6; a++) begin
      rd(4'(a), b); check("R2 staging bytes read zero", 32'(b), 32'h0);
    end
    rd(4'hE, b); check("R2 clear byte reads zero", 32'(b), 32'h0);
    rd(4'hF, b); check("R2 unmapped reads zero", 32'(b), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_count_enable();
    t_staged_load();
    t_wrap();
    t_set_time();
    t_live_read();
    t_alarm_fire();
    t_alarm_clear();
    t_alarm_disabled();
    t_set_wins();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule